// File: doc/BRIEF.md
# Page Map Flag Remapping Unit

This block owns a small table of page-map entries, indexed by virtual page, and translates each entry between the word format that software uses and the format in which the entry is stored. A software word carries three flags (write-protect, dirty, referenced) and a 12-bit real page number. Software calls an entry vacant only when write-protect and dirty are set and referenced is clear. The storage side calls any entry with write-protect and dirty set vacant, whatever referenced holds. To keep the legal software combination write-protect+dirty+referenced from reading back as vacant, the block stores dirty as 0 for that case. It then sets a substitute dirty bit in the most significant bit of the stored page field.

Commands arrive one at a time on a valid/ready port. There are three commands. Write stores a new entry and returns the previous one. Read returns the entry. Set-flags replaces the flags but keeps the stored page, and returns the previous entry. The storage write path cannot set referenced: every stored write clears it, and a requested referenced bit costs one extra access cycle. A stored page wider than the software field is reported as vacant. A build option makes the block rewrite that entry as an in-range vacant one.

Top module: `page_map_remap`

## Requirements
- R1: Result words use bit 14 (0x4000) for write-protect, bit 13 (0x2000) for dirty, bit 12 (0x1000) for referenced and bits 11:0 for the real page; bit 15 of a result is always 0. An entry written with a non-vacant flag combination reads back unchanged.
- R2: An entry stored with write-protect and dirty both set and referenced clear reads with `res_vacant`=1, and its result has write-protect=1, dirty=1 and referenced=0.
- R3: An entry written, or set by set-flags, with write-protect+dirty+referenced (0x7000 flags) reads back with `res_vacant`=0, all three flags set and the same page.
- R4: A write or set-flags that requests referenced delivers its result on the 2nd rising edge after acceptance; one that does not delivers it on the 1st edge, and the stored referenced bit is then clear.
- R5: A write whose `cmd_page_ext` is non-zero stores a page above 0xFFF; a later read of it returns `res_vacant`=1 and the word 0x6000 in both page modes.
- R6: With `REWRITE_OOR`=1 a read of such an out-of-range entry takes one extra cycle (2nd edge), and it rewrites the entry as vacant with page 0, so the next read of it arrives on the 1st edge. With `REWRITE_OOR`=0 both reads arrive on the 1st edge.
- R7: Set-flags on a non-vacant entry takes flags 14:12 from `cmd_word`, ignores its page bits, keeps the stored page, and returns the previous entry.
- R8: Set-flags on a vacant entry returns the vacant result and leaves the entry unchanged.
- R9: A vacant (non-out-of-range) entry reports its stored page in bits 11:0 when `VACANT_PAGE_ZERO`=0, and 0 there when `VACANT_PAGE_ZERO`=1.
- R10: A write returns the previous contents of the entry in result format.
- R11: `cmd_ready` is high only when no command is in progress. `res_valid` rises one cycle after the last table access of a command, and it stays high with a stable `res_word` and `res_vacant` until `res_ready` is seen. It falls on the edge that takes the result.
- R12: After reset `cmd_ready`=1 and `res_valid`=0, and every entry reads as vacant with word 0x6000.
- R13: Entries are independent: writing one virtual page, including the highest index, leaves every other entry unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command taken on this edge if valid |
| cmd_op | input | 2 | 00 write, 01 read, 10 set-flags, 11 treated as read |
| cmd_vpage | input | $clog2(DEPTH) | Virtual page index |
| cmd_word | input | PAGE_W+3 | Flags (bits 14:12) and real page (bits 11:0) in software format |
| cmd_page_ext | input | EXT_W | Upper real-page bits stored by a write, above the software field |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result taken |
| res_word | output | PAGE_W+4 | Entry in software format |
| res_vacant | output | 1 | Entry is vacant |

## Verification
Each command's latency is counted in rising edges from the accepting edge. A plain command's result is due on the 1st edge. A referenced touch or an out-of-range rewrite moves it to the 2nd. The bench samples `res_valid` on the falling edge after each rising edge and records the edge on which it first appears. It compares that count with the value the requirements give, so a result that is late, early or held back fails even when its word is right. A second instance with the other page mode and no rewrite gets the same commands, and its latency and word are checked at the same sampling points.

// File: rtl/pmr_pkg.sv
// Shared types for the page map flag remapping unit.
// Assumes: three flag bits per entry; widths of page fields come from
// the parameters of the modules that use these types.
package pmr_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b00,
        OP_READ  = 2'b01,
        OP_SETF  = 2'b10,
        OP_RSVD  = 2'b11
    } op_e;

    typedef struct packed {
        logic wp;
        logic dirty;
        logic refd;
    } flags_t;

endpackage

// File: rtl/pmr_encode.sv
// Write-path translation: software flags + real page -> stored form.
// The combination write-protect+dirty+referenced is stored with dirty
// cleared and the substitute dirty bit (page MSB) set. Referenced is never
// stored directly; need_touch asks for a later access that sets it.
// Assumes: purely combinational, RP_W real-page bits.
module pmr_encode
    import pmr_pkg::*;
#(
    parameter int RP_W = 15
) (
    input  flags_t          req,
    input  logic [RP_W-1:0] rpage,
    output logic            st_wp,
    output logic            st_dirty,
    output logic [RP_W:0]   st_page,
    output logic            need_touch
);

    logic all_three;

    // Detect the combination the storage side would misread as vacant.
    always_comb begin
        all_three  = req.wp & req.dirty & req.refd;
        st_wp      = req.wp;
        st_dirty   = req.dirty & ~all_three;
        st_page    = {all_three, rpage};
        need_touch = req.refd;
    end

endmodule

// File: rtl/pmr_decode.sv
// Read-path translation: stored entry -> software word plus vacant flag.
// Folds the substitute dirty bit into dirty, reports pages beyond the
// software field as vacant (page 0), and applies the vacant page mode.
// Assumes: purely combinational, EXT_W >= 1.
module pmr_decode
    import pmr_pkg::*;
#(
    parameter int PAGE_W           = 12,
    parameter int EXT_W            = 3,
    parameter bit VACANT_PAGE_ZERO = 1'b0,
    localparam int RP_W            = PAGE_W + EXT_W,
    localparam int SW_W            = PAGE_W + 4
) (
    input  flags_t          st_flags,
    input  logic [RP_W:0]   st_page,
    output logic [SW_W-1:0] sw_word,
    output logic            vacant,
    output logic            oor
);

    logic              sub_dirty;
    logic              hw_vacant;
    logic [PAGE_W-1:0] low_page;

    // Classify the stored entry and build the software word.
    always_comb begin
        sub_dirty = st_page[RP_W];
        low_page  = st_page[PAGE_W-1:0];
        oor       = |st_page[RP_W-1:PAGE_W];
        hw_vacant = st_flags.wp & st_flags.dirty;
        vacant    = oor | hw_vacant;
        if (oor) begin
            sw_word = {1'b0, 1'b1, 1'b1, 1'b0, {PAGE_W{1'b0}}};
        end else if (hw_vacant) begin
            sw_word = {1'b0, 1'b1, 1'b1, 1'b0,
                       (VACANT_PAGE_ZERO ? {PAGE_W{1'b0}} : low_page)};
        end else begin
            sw_word = {1'b0, st_flags.wp, st_flags.dirty | sub_dirty,
                       st_flags.refd, low_page};
        end
    end

endmodule

// File: rtl/pmr_table.sv
// Register array of stored map entries, one per virtual page.
// One combinational read port, one write port that always clears the
// referenced bit, and a touch port that only sets referenced.
// Assumes: write and touch never target the same cycle; reset makes every
// entry vacant (write-protect+dirty, page 0).
module pmr_table
    import pmr_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int ST_W  = 16,
    localparam int VA_W = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [VA_W-1:0] rd_idx,
    output flags_t          rd_flags,
    output logic [ST_W-1:0] rd_page,
    input  logic            wr_en,
    input  logic [VA_W-1:0] wr_idx,
    input  logic            wr_wp,
    input  logic            wr_dirty,
    input  logic [ST_W-1:0] wr_page,
    input  logic            touch_en,
    input  logic [VA_W-1:0] touch_idx
);

    flags_t          ent_flags [DEPTH];
    logic [ST_W-1:0] ent_page  [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        // Per-entry storage: reset to vacant, write clears ref, touch sets it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_flags[i] <= '{wp: 1'b1, dirty: 1'b1, refd: 1'b0};
                ent_page[i]  <= '0;
            end else if (wr_en && wr_idx == VA_W'(i)) begin
                ent_flags[i] <= '{wp: wr_wp, dirty: wr_dirty, refd: 1'b0};
                ent_page[i]  <= wr_page;
            end else if (touch_en && touch_idx == VA_W'(i)) begin
                ent_flags[i].refd <= 1'b1;
            end
        end
    end

    // Read port.
    always_comb begin
        rd_flags = ent_flags[rd_idx];
        rd_page  = ent_page[rd_idx];
    end

    // R4: a stored write leaves referenced clear in the entry it wrote.
    a_r4_write_clears_ref: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !ent_flags[$past(wr_idx)].refd);

    // R3: the substitute dirty bit never travels with a stored dirty bit.
    a_r3_sub_excludes_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_page[ST_W-1]) |-> !wr_dirty);

endmodule

// File: rtl/page_map_remap.sv
// Page map flag remapping unit: command sequencer around the entry table.
// One command at a time: LOOK reads (and for writes, stores) the entry,
// TOUCH sets referenced, FIX rewrites an out-of-range entry as vacant,
// DONE holds the result until taken.
// Assumes: EXT_W >= 1, DEPTH >= 2.
module page_map_remap
    import pmr_pkg::*;
#(
    parameter int DEPTH            = 64,
    parameter int PAGE_W           = 12,
    parameter int EXT_W            = 3,
    parameter bit VACANT_PAGE_ZERO = 1'b0,
    parameter bit REWRITE_OOR      = 1'b1,
    localparam int VA_W            = $clog2(DEPTH),
    localparam int SW_W            = PAGE_W + 4,
    localparam int RP_W            = PAGE_W + EXT_W,
    localparam int ST_W            = RP_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [VA_W-1:0]   cmd_vpage,
    input  logic [SW_W-2:0]   cmd_word,
    input  logic [EXT_W-1:0]  cmd_page_ext,
    output logic              res_valid,
    input  logic              res_ready,
    output logic [SW_W-1:0]   res_word,
    output logic              res_vacant
);

    localparam int RF_B = PAGE_W;
    localparam int DT_B = PAGE_W + 1;
    localparam int WP_B = PAGE_W + 2;

    typedef enum logic [2:0] {
        S_IDLE, S_LOOK, S_TOUCH, S_FIX, S_DONE
    } state_e;

    state_e            state_q, state_d;
    op_e               op_q;
    logic [VA_W-1:0]   vp_q;
    logic [SW_W-2:0]   word_q;
    logic [EXT_W-1:0]  ext_q;
    logic [SW_W-1:0]   res_word_q;
    logic              res_vac_q;

    flags_t            rd_flags;
    logic [ST_W-1:0]   rd_page;
    logic [SW_W-1:0]   dec_word;
    logic              dec_vac;
    logic              dec_oor;

    flags_t            req_flags;
    logic [RP_W-1:0]   enc_rp;
    logic              enc_wp, enc_dirty, enc_touch;
    logic [ST_W-1:0]   enc_page;

    logic              look_write, fix_write;
    logic              wr_en, wr_wp, wr_dirty, touch_en;
    logic [ST_W-1:0]   wr_page;

    pmr_table #(.DEPTH(DEPTH), .ST_W(ST_W)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (vp_q),
        .rd_flags  (rd_flags),
        .rd_page   (rd_page),
        .wr_en     (wr_en),
        .wr_idx    (vp_q),
        .wr_wp     (wr_wp),
        .wr_dirty  (wr_dirty),
        .wr_page   (wr_page),
        .touch_en  (touch_en),
        .touch_idx (vp_q)
    );

    pmr_decode #(.PAGE_W(PAGE_W), .EXT_W(EXT_W),
                 .VACANT_PAGE_ZERO(VACANT_PAGE_ZERO)) u_decode (
        .st_flags (rd_flags),
        .st_page  (rd_page),
        .sw_word  (dec_word),
        .vacant   (dec_vac),
        .oor      (dec_oor)
    );

    pmr_encode #(.RP_W(RP_W)) u_encode (
        .req        (req_flags),
        .rpage      (enc_rp),
        .st_wp      (enc_wp),
        .st_dirty   (enc_dirty),
        .st_page    (enc_page),
        .need_touch (enc_touch)
    );

    // Requested flags and page: set-flags keeps the stored page.
    always_comb begin
        req_flags = '{wp: word_q[WP_B], dirty: word_q[DT_B], refd: word_q[RF_B]};
        if (op_q == OP_SETF) begin
            enc_rp = {{EXT_W{1'b0}}, dec_word[PAGE_W-1:0]};
        end else begin
            enc_rp = {ext_q, word_q[PAGE_W-1:0]};
        end
    end

    // Table access strobes for the current state.
    always_comb begin
        look_write = (state_q == S_LOOK) &&
                     ((op_q == OP_WRITE) || (op_q == OP_SETF && !dec_vac));
        fix_write  = (state_q == S_FIX);
        wr_en      = look_write | fix_write;
        wr_wp      = fix_write ? 1'b1 : enc_wp;
        wr_dirty   = fix_write ? 1'b1 : enc_dirty;
        wr_page    = fix_write ? '0   : enc_page;
        touch_en   = (state_q == S_TOUCH);
    end

    // Next-state choice.
    always_comb begin
        state_d = state_q;
        case (state_q)
            S_IDLE:  if (cmd_valid) state_d = S_LOOK;
            S_LOOK: begin
                if (look_write && enc_touch) begin
                    state_d = S_TOUCH;
                end else if (!look_write && op_q != OP_SETF &&
                             dec_oor && REWRITE_OOR) begin
                    state_d = S_FIX;
                end else begin
                    state_d = S_DONE;
                end
            end
            S_TOUCH: state_d = S_DONE;
            S_FIX:   state_d = S_DONE;
            S_DONE:  if (res_ready) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State, captured command and captured result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            op_q       <= OP_READ;
            vp_q       <= '0;
            word_q     <= '0;
            ext_q      <= '0;
            res_word_q <= '0;
            res_vac_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && cmd_valid) begin
                op_q   <= op_e'(cmd_op);
                vp_q   <= cmd_vpage;
                word_q <= cmd_word;
                ext_q  <= cmd_page_ext;
            end
            if (state_q == S_LOOK) begin
                res_word_q <= dec_word;
                res_vac_q  <= dec_vac;
            end
        end
    end

    assign cmd_ready  = (state_q == S_IDLE);
    assign res_valid  = (state_q == S_DONE);
    assign res_word   = res_word_q;
    assign res_vacant = res_vac_q;

    // R11: a pending result holds steady until taken.
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_word) && $stable(res_vacant)));

    // R11: no new command is taken while a result is outstanding.
    a_r11_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !res_valid);

    // R4: referenced is set only right after a stored write.
    a_r4_touch_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |-> $past(wr_en));

    // R2: a vacant result carries write-protect and dirty without referenced.
    a_r2_vacant_word: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_vacant) |-> (res_word[WP_B] && res_word[DT_B] && !res_word[RF_B]));

    // R1: the top bit of a result is always zero.
    a_r1_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !res_word[SW_W-1]);

endmodule

// File: tb/tb_page_map_remap.sv
`timescale 1ns/1ps
module tb_page_map_remap;

    localparam int VA_W = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b01;
    logic [5:0]  cmd_vpage = '0;
    logic [14:0] cmd_word = '0;
    logic [2:0]  cmd_page_ext = '0;
    logic        res_ready = 1'b0;

    logic        cmd_ready, res_valid, res_vacant;
    logic [15:0] res_word;
    logic        cmd_ready_a, res_valid_a, res_vacant_a;
    logic [15:0] res_word_a;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    page_map_remap dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_vpage(cmd_vpage), .cmd_word(cmd_word),
        .cmd_page_ext(cmd_page_ext), .res_valid(res_valid), .res_ready(res_ready),
        .res_word(res_word), .res_vacant(res_vacant)
    );

    page_map_remap #(.VACANT_PAGE_ZERO(1'b1), .REWRITE_OOR(1'b0)) dut_alt (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready_a),
        .cmd_op(cmd_op), .cmd_vpage(cmd_vpage), .cmd_word(cmd_word),
        .cmd_page_ext(cmd_page_ext), .res_valid(res_valid_a), .res_ready(res_ready),
        .res_word(res_word_a), .res_vacant(res_vacant_a)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [1:0]  op;
        logic [5:0]  vp;
        logic [15:0] word;
        logic [2:0]  ext;
        logic [15:0] exp;
        logic        vac;
        logic [15:0] expa;
        logic [1:0]  lat;
        logic [1:0]  lata;
    } vec_t;

    localparam int NV = 23;
    // op: 0 write, 1 read, 2 set-flags
    localparam vec_t VECS [NV] = '{
        '{4'd12, 2'd1, 6'd5,  16'h0000, 3'd0, 16'h6000, 1'b1, 16'h6000, 2'd1, 2'd1}, // R12
        '{4'd10, 2'd0, 6'd5,  16'h4123, 3'd0, 16'h6000, 1'b1, 16'h6000, 2'd1, 2'd1}, // R10
        '{4'd1,  2'd1, 6'd5,  16'h0000, 3'd0, 16'h4123, 1'b0, 16'h4123, 2'd1, 2'd1}, // R1
        '{4'd4,  2'd0, 6'd7,  16'h3456, 3'd0, 16'h6000, 1'b1, 16'h6000, 2'd2, 2'd2}, // R4
        '{4'd4,  2'd1, 6'd7,  16'h0000, 3'd0, 16'h3456, 1'b0, 16'h3456, 2'd1, 2'd1}, // R4
        '{4'd3,  2'd0, 6'd9,  16'h7ABC, 3'd0, 16'h6000, 1'b1, 16'h6000, 2'd2, 2'd2}, // R3
        '{4'd3,  2'd1, 6'd9,  16'h0000, 3'd0, 16'h7ABC, 1'b0, 16'h7ABC, 2'd1, 2'd1}, // R3
        '{4'd2,  2'd0, 6'd11, 16'h6222, 3'd0, 16'h6000, 1'b1, 16'h6000, 2'd1, 2'd1}, // R2
        '{4'd9,  2'd1, 6'd11, 16'h0000, 3'd0, 16'h6222, 1'b1, 16'h6000, 2'd1, 2'd1}, // R9, R2
        '{4'd8,  2'd2, 6'd11, 16'h1000, 3'd0, 16'h6222, 1'b1, 16'h6000, 2'd1, 2'd1}, // R8
        '{4'd8,  2'd1, 6'd11, 16'h0000, 3'd0, 16'h6222, 1'b1, 16'h6000, 2'd1, 2'd1}, // R8
        '{4'd7,  2'd2, 6'd5,  16'h2FFF, 3'd0, 16'h4123, 1'b0, 16'h4123, 2'd1, 2'd1}, // R7
        '{4'd7,  2'd1, 6'd5,  16'h0000, 3'd0, 16'h2123, 1'b0, 16'h2123, 2'd1, 2'd1}, // R7
        '{4'd3,  2'd2, 6'd5,  16'h7000, 3'd0, 16'h2123, 1'b0, 16'h2123, 2'd2, 2'd2}, // R3
        '{4'd3,  2'd1, 6'd5,  16'h0000, 3'd0, 16'h7123, 1'b0, 16'h7123, 2'd1, 2'd1}, // R3
        '{4'd4,  2'd2, 6'd7,  16'h0000, 3'd0, 16'h3456, 1'b0, 16'h3456, 2'd1, 2'd1}, // R4
        '{4'd4,  2'd1, 6'd7,  16'h0000, 3'd0, 16'h0456, 1'b0, 16'h0456, 2'd1, 2'd1}, // R4
        '{4'd5,  2'd0, 6'd20, 16'h1055, 3'd2, 16'h6000, 1'b1, 16'h6000, 2'd2, 2'd2}, // R5
        '{4'd6,  2'd1, 6'd20, 16'h0000, 3'd0, 16'h6000, 1'b1, 16'h6000, 2'd2, 2'd1}, // R6, R5
        '{4'd6,  2'd1, 6'd20, 16'h0000, 3'd0, 16'h6000, 1'b1, 16'h6000, 2'd1, 2'd1}, // R6
        '{4'd13, 2'd0, 6'd63, 16'h0FFF, 3'd0, 16'h6000, 1'b1, 16'h6000, 2'd1, 2'd1}, // R13
        '{4'd13, 2'd1, 6'd63, 16'h0000, 3'd0, 16'h0FFF, 1'b0, 16'h0FFF, 2'd1, 2'd1}, // R13
        '{4'd13, 2'd1, 6'd0,  16'h0000, 3'd0, 16'h6000, 1'b1, 16'h6000, 2'd1, 2'd1}  // R13
    };

    task automatic check_eq(input string what, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // Issue one command to both instances, collect both results, then take them.
    task automatic do_cmd(input logic [1:0] op, input logic [5:0] vp, input logic [15:0] word,
                          input logic [2:0] ext, input int hold,
                          output logic [15:0] w, output logic v,
                          output logic [15:0] wa, output logic va,
                          output int lat, output int lata);
        int n;
        w = 'x; wa = 'x; v = 'x; va = 'x;
        @(negedge clk);
        cmd_op = op; cmd_vpage = vp; cmd_word = word[14:0]; cmd_page_ext = ext;
        cmd_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        check_eq("R11 cmd_ready low while busy", {15'b0, cmd_ready}, 16'h0);
        lat = -1; lata = -1; n = 0;
        while ((lat < 0 || lata < 0) && n < 16) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (lat < 0 && res_valid) begin
                lat = n; w = res_word; v = res_vacant;
            end
            if (lata < 0 && res_valid_a) begin
                lata = n; wa = res_word_a; va = res_vacant_a;
            end
        end
        if (hold > 0) begin
            repeat (hold) @(negedge clk);
            check_eq("R11 result held valid", {15'b0, res_valid}, 16'h1);
            check_eq("R11 result word stable", res_word, w);
        end
        res_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        res_ready = 1'b0;
        check_eq("R11 res_valid falls after take", {15'b0, res_valid}, 16'h0);
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] w, wa;
        logic        v, va;
        int          lat, lata;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R12 cmd_ready after reset", {15'b0, cmd_ready}, 16'h1);
        check_eq("R12 res_valid after reset", {15'b0, res_valid}, 16'h0);
        check_eq("R12 alt res_valid after reset", {15'b0, res_valid_a}, 16'h0);

        for (int i = 0; i < NV; i++) begin
            do_cmd(VECS[i].op, VECS[i].vp, VECS[i].word, VECS[i].ext, 0, w, v, wa, va, lat, lata);
            check_eq($sformatf("vector %0d R%0d word", i, VECS[i].req), w, VECS[i].exp);
            check_eq($sformatf("vector %0d R%0d vacant", i, VECS[i].req), {15'b0, v}, {15'b0, VECS[i].vac});
            check_eq($sformatf("vector %0d R%0d alt word", i, VECS[i].req), wa, VECS[i].expa);
            check_eq($sformatf("vector %0d R%0d alt vacant", i, VECS[i].req), {15'b0, va}, {15'b0, VECS[i].vac});
            check_eq($sformatf("vector %0d R%0d latency", i, VECS[i].req), 16'(lat), {14'b0, VECS[i].lat});
            check_eq($sformatf("vector %0d R%0d alt latency", i, VECS[i].req), 16'(lata), {14'b0, VECS[i].lata});
        end

        // R11: result held for three cycles before being taken
        do_cmd(2'd1, 6'd9, 16'h0, 3'd0, 3, w, v, wa, va, lat, lata);
        check_eq("R11 held read word", w, 16'h7ABC);

        // R12: reset returns every entry to vacant
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R12 cmd_ready after second reset", {15'b0, cmd_ready}, 16'h1);
        do_cmd(2'd1, 6'd5, 16'h0, 3'd0, 0, w, v, wa, va, lat, lata);
        check_eq("R12 entry 5 vacant after reset", w, 16'h6000);
        check_eq("R12 entry 5 vacant flag", {15'b0, v}, 16'h1);
        do_cmd(2'd1, 6'd9, 16'h0, 3'd0, 0, w, v, wa, va, lat, lata);
        check_eq("R12 entry 9 vacant after reset", w, 16'h6000);

        summary();
        $finish;
    end

endmodule